// File: doc/BRIEF.md
# CPU to ISA I/O Bridge

This block sits between a CPU load/store port and an ISA-style port bus. It claims two CPU address windows. The first is an 8 MB I/O window starting at 0x80000000. Accesses there become single ISA port cycles. The second is a 4-byte interrupt-acknowledge window at 0xBFFFFFF0. A read there fetches a vector from an external interrupt controller.

For the I/O window, the CPU address is turned into a 16-bit port address in one of two ways. A map-type input picks the scheme when the access is accepted:
- **Dense:** the port address is simply the low 16 address bits.
- **Sparse:** the low five bits are kept, and every 4 KB page of the window supplies the upper port bits.

Halfword and word data are byte-swapped in both directions, so a big-endian CPU sees little-endian ISA devices in their natural byte order.

Only one transaction is in flight at a time. The CPU holds `cpu_req` and its fields steady until it sees `cpu_ack`, which is high for exactly one cycle. The CPU drops `cpu_req` in the cycle after `cpu_ack`. Accesses outside both windows are never acknowledged.

Top module: `isa_io_bridge`

## Requirements
- R1: Addresses 0x80000000 to 0x807FFFFF, and 0xBFFFFFF0 to 0xBFFFFFF3, are claimed. Any other address raises neither `isa_req` nor `inta_req`, and never `cpu_ack`.
- R2: With `map_sparse`=0 at acceptance, `isa_port` equals CPU address bits [15:0].
- R3: With `map_sparse`=1 at acceptance, `isa_port` equals (addr & 0x1F) | ((addr & 0x07FFF000) >> 7), truncated to 16 bits. For example, 0x807FFFFF gives 0xFFFF.
- R4: Write data is lane-swapped by `cpu_size`, with the result on `isa_wdata`:
  - size 0 (byte): wdata[7:0] is passed on, with the upper bytes zero.
  - size 1 (half): {16'h0, wdata[7:0], wdata[15:8]}.
  - size 2 (word): the four bytes are reversed.
- R5: Read data from `isa_rdata` is returned on `cpu_rdata`, lane-swapped by the same rule as R4.
- R6: `isa_req` rises in the cycle after an I/O access is accepted. It stays high, with port, direction, size and data stable, until `isa_rdy` is sampled high. `cpu_ack` is high for exactly one cycle, the cycle after `isa_rdy` was sampled.
- R7: A read at offset 0 of the acknowledge window pulses `inta_req` for one cycle and then waits for `inta_valid`. `cpu_ack` follows one cycle after `inta_valid`, with the zero-extended 8-bit vector lane-swapped as in R5.
- R8: A read at offset 1, 2 or 3 of the acknowledge window returns 0 with `cpu_ack` one cycle after acceptance. No `inta_req` is raised.
- R9: A write to the acknowledge window is acknowledged one cycle after acceptance and is discarded: neither `inta_req` nor `isa_req` is raised.
- R10: After a synchronous active-low reset, `isa_req`, `inta_req` and `cpu_ack` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| map_sparse | input | 1 | Map type: 0 dense, 1 sparse |
| cpu_req | input | 1 | CPU access request, held until ack |
| cpu_we | input | 1 | 1 write, 0 read |
| cpu_size | input | 2 | 0 byte, 1 half, 2 word |
| cpu_addr | input | 32 | CPU byte address |
| cpu_wdata | input | 32 | CPU write data |
| cpu_rdata | output | 32 | Read data, valid with cpu_ack |
| cpu_ack | output | 1 | One-cycle completion strobe |
| isa_req | output | 1 | ISA port cycle request |
| isa_we | output | 1 | ISA cycle direction |
| isa_size | output | 2 | ISA cycle size |
| isa_port | output | 16 | ISA port address |
| isa_wdata | output | 32 | Swapped write data |
| isa_rdata | input | 32 | ISA read data, valid with isa_rdy |
| isa_rdy | input | 1 | ISA cycle complete |
| inta_req | output | 1 | Interrupt-acknowledge pulse |
| inta_valid | input | 1 | Vector valid |
| inta_vec | input | 8 | Interrupt vector |

## Verification
The translator is driven with the same address family in both map types, so a mix-up between the dense and sparse formulas shows up as a wrong port. The top and bottom edges of the I/O window, plus one address just outside each edge, separate a correct bound from an off-by-one claim.

Each access size is used for reads and for writes, with byte patterns that are all distinct. A wrong lane order or an unmasked upper byte therefore shows up in the data.

ISA ready latencies of one to four cycles, and interrupt-controller latencies of one and more than one cycle, check that the acknowledge follows the response and not a fixed count. Acknowledge-window reads at each offset, and writes there, check that only an offset-0 read reaches the controller.

// File: rtl/isa_bridge_pkg.sv
// Shared types for the CPU to ISA I/O bridge.
// Assumes: access size encoding 0 byte, 1 half, 2 word.
package isa_bridge_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_ISA       = 3'd1,
        ST_INTA_REQ  = 3'd2,
        ST_INTA_WAIT = 3'd3,
        ST_DONE      = 3'd4
    } brg_state_e;

endpackage

// File: rtl/isa_addr_decode.sv
// Window decoder and port address translator.
// Claims the I/O window [IO_BASE, IO_BASE+IO_SPAN) and a 4-byte
// acknowledge window at ACK_BASE. It produces the dense or the sparse
// port address for the current CPU address.
// Assumes: ACK_BASE is 4-byte aligned; the I/O window lies below 2^ADDR_W.
module isa_addr_decode #(
    parameter int              ADDR_W   = 32,
    parameter int              PORT_W   = 16,
    parameter int              LOW_BITS = 5,
    parameter int              PAGE_SH  = 12,
    parameter logic [ADDR_W-1:0] IO_BASE  = 32'h8000_0000,
    parameter logic [ADDR_W-1:0] IO_SPAN  = 32'h0080_0000,
    parameter logic [ADDR_W-1:0] ACK_BASE = 32'hBFFF_FFF0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              sparse,
    output logic              io_hit,
    output logic              ack_hit,
    output logic              ack_zero_off,
    output logic [PORT_W-1:0] port
);
    localparam int              HIGH_BITS = PORT_W - LOW_BITS;
    localparam logic [ADDR_W:0] IO_LO     = {1'b0, IO_BASE};
    localparam logic [ADDR_W:0] IO_HI     = {1'b0, IO_BASE} + {1'b0, IO_SPAN};

    logic [ADDR_W:0]   addr_x;
    logic [PORT_W-1:0] dense_port;
    logic [PORT_W-1:0] sparse_port;

    // Window membership tests.
    always_comb begin
        addr_x       = {1'b0, addr};
        io_hit       = (addr_x >= IO_LO) && (addr_x < IO_HI);
        ack_hit      = (addr[ADDR_W-1:2] == ACK_BASE[ADDR_W-1:2]);
        ack_zero_off = (addr[1:0] == 2'b00);
    end

    // Two translation schemes; the map-type input picks one.
    always_comb begin
        dense_port  = addr[PORT_W-1:0];
        sparse_port = {addr[PAGE_SH +: HIGH_BITS], addr[LOW_BITS-1:0]};
        port        = sparse ? sparse_port : dense_port;
    end

    // R1: the two windows never overlap.
    always_comb begin
        window_excl_chk: assert (!(io_hit && ack_hit));
    end

endmodule

// File: rtl/isa_lane_swap.sv
// Byte-lane reorder by access size.
// Byte: lane 0 kept. Half: lanes 0 and 1 exchanged. Word: all lanes reversed.
// Lanes not covered by the access size are zero; size 3 behaves as word.
// Assumes: DATA_W is a multiple of 16.
module isa_lane_swap
    import isa_bridge_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    localparam int NBYTES = DATA_W / 8;

    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        // Select the source lane for output byte b.
        always_comb begin
            case (size)
                SZ_BYTE: dout[b*8 +: 8] = (b == 0) ? din[7:0] : 8'h00;
                SZ_HALF: dout[b*8 +: 8] = (b < 2) ? din[(1-b)*8 +: 8] : 8'h00;
                default: dout[b*8 +: 8] = din[(NBYTES-1-b)*8 +: 8];
            endcase
        end
    end

endmodule

// File: rtl/isa_io_bridge.sv
// CPU to ISA I/O bridge top.
// Accepts one CPU access at a time. It runs an ISA port cycle for the
// I/O window and an acknowledge cycle for the vector window, then returns
// a one-cycle cpu_ack.
// Assumes: the CPU holds req and its fields until ack and drops req in
// the cycle after ack; isa_rdy and inta_valid are only seen while waiting.
module isa_io_bridge
    import isa_bridge_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PORT_W = 16,
    parameter int VEC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              map_sparse,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [1:0]        cpu_size,
    input  logic [31:0]       cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ack,
    output logic              isa_req,
    output logic              isa_we,
    output logic [1:0]        isa_size,
    output logic [PORT_W-1:0] isa_port,
    output logic [DATA_W-1:0] isa_wdata,
    input  logic [DATA_W-1:0] isa_rdata,
    input  logic              isa_rdy,
    output logic              inta_req,
    input  logic              inta_valid,
    input  logic [VEC_W-1:0]  inta_vec
);
    localparam int VEC_PAD = DATA_W - VEC_W;

    brg_state_e        state;
    logic              io_hit, ack_hit, ack_zero_off;
    logic [PORT_W-1:0] xport;
    logic [DATA_W-1:0] wswap, rd_src, rswap;
    logic              in_inta;
    logic              txn_we;
    logic [1:0]        txn_size;
    logic [PORT_W-1:0] txn_port;
    logic [DATA_W-1:0] txn_wdata, rdata_q;

    isa_addr_decode #(.PORT_W(PORT_W)) u_decode (
        .addr         (cpu_addr),
        .sparse       (map_sparse),
        .io_hit       (io_hit),
        .ack_hit      (ack_hit),
        .ack_zero_off (ack_zero_off),
        .port         (xport)
    );

    isa_lane_swap #(.DATA_W(DATA_W)) u_wswap (
        .size (cpu_size),
        .din  (cpu_wdata),
        .dout (wswap)
    );

    // Read source: the vector during acknowledge, the ISA data otherwise.
    always_comb begin
        in_inta = (state == ST_INTA_REQ) || (state == ST_INTA_WAIT);
        rd_src  = in_inta ? {{VEC_PAD{1'b0}}, inta_vec} : isa_rdata;
    end

    isa_lane_swap #(.DATA_W(DATA_W)) u_rswap (
        .size (txn_size),
        .din  (rd_src),
        .dout (rswap)
    );

    // Transaction sequencer: accept, wait for the responder, acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            txn_we    <= 1'b0;
            txn_size  <= SZ_BYTE;
            txn_port  <= '0;
            txn_wdata <= '0;
            rdata_q   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (cpu_req && io_hit) begin
                        state     <= ST_ISA;
                        txn_we    <= cpu_we;
                        txn_size  <= cpu_size;
                        txn_port  <= xport;
                        txn_wdata <= wswap;
                    end else if (cpu_req && ack_hit) begin
                        txn_size <= cpu_size;
                        rdata_q  <= '0;
                        state    <= (!cpu_we && ack_zero_off) ? ST_INTA_REQ : ST_DONE;
                    end
                end
                ST_ISA: begin
                    if (isa_rdy) begin
                        rdata_q <= rswap;
                        state   <= ST_DONE;
                    end
                end
                ST_INTA_REQ, ST_INTA_WAIT: begin
                    if (inta_valid) begin
                        rdata_q <= rswap;
                        state   <= ST_DONE;
                    end else begin
                        state <= ST_INTA_WAIT;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Outputs decoded from state and the held transaction.
    always_comb begin
        isa_req   = (state == ST_ISA);
        inta_req  = (state == ST_INTA_REQ);
        cpu_ack   = (state == ST_DONE);
        isa_we    = txn_we;
        isa_size  = txn_size;
        isa_port  = txn_port;
        isa_wdata = txn_wdata;
        cpu_rdata = rdata_q;
    end

    // R6
    isa_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        isa_req && !isa_rdy |=> isa_req && $stable(isa_port) && $stable(isa_wdata)
                                && $stable(isa_we) && $stable(isa_size));
    // R6
    ack_after_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        isa_req && isa_rdy |=> cpu_ack && !isa_req);
    // R6
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |=> !cpu_ack);
    // R7
    inta_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inta_req |=> !inta_req);
    // R7
    inta_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_inta && inta_valid |=> cpu_ack);
    // R8
    ack_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE && cpu_req && ack_hit && !cpu_we && !ack_zero_off
        |=> cpu_ack && !inta_req && cpu_rdata == '0);
    // R9
    ack_wr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE && cpu_req && ack_hit && cpu_we |=> cpu_ack && !inta_req && !isa_req);
    // R1
    unclaimed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE && cpu_req && !io_hit && !ack_hit |=> !cpu_ack && !isa_req && !inta_req);
    // R1
    one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(isa_req && inta_req));

endmodule

// File: tb/isa_io_bridge_tb.sv
module isa_io_bridge_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        map_sparse = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [1:0]  cpu_size = 2'd0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_ack, isa_req, isa_we, inta_req;
    logic [1:0]  isa_size;
    logic [15:0] isa_port;
    logic [31:0] isa_wdata;
    logic [31:0] isa_rdata = '0;
    logic        isa_rdy = 1'b0, inta_valid = 1'b0;
    logic [7:0]  inta_vec = '0;

    int n_checks = 0;
    int n_err    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    isa_io_bridge u_dut (
        .clk(clk), .rst_n(rst_n), .map_sparse(map_sparse),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_size(cpu_size),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_ack(cpu_ack), .isa_req(isa_req), .isa_we(isa_we),
        .isa_size(isa_size), .isa_port(isa_port), .isa_wdata(isa_wdata),
        .isa_rdata(isa_rdata), .isa_rdy(isa_rdy), .inta_req(inta_req),
        .inta_valid(inta_valid), .inta_vec(inta_vec)
    );

    // Reference: lane reorder from the requirement text.
    function automatic logic [31:0] ref_swap(logic [31:0] d, int sz);
        logic [31:0] r;
        r = 32'h0;
        if (sz == 0) begin
            r = d % 256;
        end else if (sz == 1) begin
            r = (d % 256) * 256 + (d / 256) % 256;
        end else begin
            for (int i = 0; i < 4; i++)
                r = r * 256 + (d / (32'h1 << (8 * i))) % 256;
        end
        return r;
    endfunction

    // Reference: port address by arithmetic.
    function automatic logic [31:0] ref_port(logic [31:0] a, logic sp);
        if (sp) return ((a / 4096) % 32768 * 32 + a % 32) % 65536;
        return a % 65536;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic we, input int sz, input logic [31:0] a, input logic [31:0] wd);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_size = sz[1:0]; cpu_addr = a; cpu_wdata = wd;
    endtask

    // I/O window access with an ISA responder of the given latency.
    task automatic io_txn(input logic we, input int sz, input logic [31:0] a,
                          input logic [31:0] wd, input logic sp,
                          input logic [31:0] dev, input int lat);
        map_sparse = sp;
        drive(we, sz, a, wd);
        for (int k = 1; k <= lat; k++) begin
            @(negedge clk);
            chk("R6 isa_req held", {31'h0, isa_req}, 32'h1);
            chk("R6 ack low while waiting", {31'h0, cpu_ack}, 32'h0);
            chk("R1 no inta on io", {31'h0, inta_req}, 32'h0);
            chk("R6 isa_we", {31'h0, isa_we}, {31'h0, we});
            chk("R6 isa_size", {30'h0, isa_size}, sz);
            if (sp) chk("R3 sparse port", {16'h0, isa_port}, ref_port(a, 1'b1));
            else    chk("R2 dense port", {16'h0, isa_port}, ref_port(a, 1'b0));
            if (we) chk("R4 write swap", isa_wdata, ref_swap(wd, sz));
            if (k == lat) begin isa_rdy = 1'b1; isa_rdata = dev; end
            map_sparse = ~sp;   // later changes must not matter
        end
        @(negedge clk);
        chk("R6 ack after rdy", {31'h0, cpu_ack}, 32'h1);
        chk("R6 isa_req dropped", {31'h0, isa_req}, 32'h0);
        if (!we) chk("R5 read swap", cpu_rdata, ref_swap(dev, sz));
        cpu_req = 1'b0; isa_rdy = 1'b0; map_sparse = sp;
        @(negedge clk);
        chk("R6 ack one cycle", {31'h0, cpu_ack}, 32'h0);
    endtask

    // Offset-0 acknowledge read with a controller of the given latency.
    task automatic inta_txn(input int sz, input logic [7:0] vec, input int lat);
        drive(1'b0, sz, 32'hBFFF_FFF0, 32'h0);
        for (int k = 1; k <= lat; k++) begin
            @(negedge clk);
            chk("R7 inta pulse", {31'h0, inta_req}, (k == 1) ? 32'h1 : 32'h0);
            chk("R7 no isa", {31'h0, isa_req}, 32'h0);
            chk("R7 ack waits", {31'h0, cpu_ack}, 32'h0);
            if (k == lat) begin inta_valid = 1'b1; inta_vec = vec; end
        end
        @(negedge clk);
        chk("R7 ack after valid", {31'h0, cpu_ack}, 32'h1);
        chk("R7 vector swap", cpu_rdata, ref_swap({24'h0, vec}, sz));
        inta_valid = 1'b0; cpu_req = 1'b0;
        @(negedge clk);
        chk("R7 ack one cycle", {31'h0, cpu_ack}, 32'h0);
    endtask

    // Acknowledge-window access completed without the controller.
    task automatic ack_direct(input logic we, input int sz, input int off, input string tag);
        drive(we, sz, 32'hBFFF_FFF0 + off, 32'hFFFF_FFFF);
        @(negedge clk);
        chk({tag, " ack"}, {31'h0, cpu_ack}, 32'h1);
        chk({tag, " no inta"}, {31'h0, inta_req}, 32'h0);
        chk({tag, " no isa"}, {31'h0, isa_req}, 32'h0);
        if (!we) chk({tag, " zero data"}, cpu_rdata, 32'h0);
        cpu_req = 1'b0;
        @(negedge clk);
        chk({tag, " ack low"}, {31'h0, cpu_ack}, 32'h0);
        chk({tag, " inta low"}, {31'h0, inta_req}, 32'h0);
    endtask

    task automatic unclaimed(input logic [31:0] a);
        drive(1'b0, 2, a, 32'h0);
        repeat (4) begin
            @(negedge clk);
            chk("R1 unclaimed no ack", {31'h0, cpu_ack}, 32'h0);
            chk("R1 unclaimed no isa", {31'h0, isa_req}, 32'h0);
            chk("R1 unclaimed no inta", {31'h0, inta_req}, 32'h0);
        end
        cpu_req = 1'b0;
        @(negedge clk);
    endtask

    // Every clock: the two responder requests are never both active.
    always @(negedge clk) begin
        if (rst_n && isa_req && inta_req) begin
            n_err++;
            $display("FAIL R1 both requests actual=11 expected=not both");
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 isa_req reset", {31'h0, isa_req}, 32'h0);
        chk("R10 inta_req reset", {31'h0, inta_req}, 32'h0);
        chk("R10 ack reset", {31'h0, cpu_ack}, 32'h0);
        rst_n = 1'b1;

        // Dense and sparse maps with reads of each size.
        io_txn(1'b0, 0, 32'h8000_03F8, 32'h0, 1'b0, 32'h1234_5678, 1);
        io_txn(1'b0, 1, 32'h8000_1234, 32'h0, 1'b0, 32'hAABB_CCDD, 3);
        io_txn(1'b0, 2, 32'h8012_3456, 32'h0, 1'b1, 32'h1122_3344, 2);
        io_txn(1'b0, 1, 32'h8012_3456, 32'h0, 1'b0, 32'h5566_7788, 1);
        // Writes of each size.
        io_txn(1'b1, 2, 32'h8000_0070, 32'hCAFE_F00D, 1'b0, 32'h0, 2);
        io_txn(1'b1, 1, 32'h8005_A01B, 32'h9876_5432, 1'b1, 32'h0, 4);
        io_txn(1'b1, 0, 32'h8000_0092, 32'hA1B2_C3D4, 1'b0, 32'h0, 1);
        // Window edges.
        io_txn(1'b0, 2, 32'h807F_FFFF, 32'h0, 1'b1, 32'h0102_0304, 1);
        io_txn(1'b0, 0, 32'h8000_0000, 32'h0, 1'b1, 32'h0000_00E7, 1);
        unclaimed(32'h8080_0000);
        unclaimed(32'h7FFF_FFFF);
        unclaimed(32'hBFFF_FFEC);
        unclaimed(32'hBFFF_FFF4);
        // Acknowledge window.
        inta_txn(2, 8'h5A, 2);
        inta_txn(1, 8'h21, 1);
        inta_txn(0, 8'hC3, 3);
        ack_direct(1'b0, 2, 1, "R8 offset1");
        ack_direct(1'b0, 0, 2, "R8 offset2");
        ack_direct(1'b0, 1, 3, "R8 offset3");
        ack_direct(1'b1, 2, 0, "R9 write");
        ack_direct(1'b1, 0, 2, "R9 write off");
        // Bridge still works after acknowledge traffic.
        io_txn(1'b0, 2, 32'h8000_0CF8, 32'h0, 1'b0, 32'hDEAD_BEEF, 2);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule